// File: doc/BRIEF.md
# Sectioned Register Access Controller

This block sits behind the byte layer of a serial slave port and turns its byte events into accesses on a small register map. The framer tells it when a transfer opens or closes, when an address byte arrives, and when a data byte is written or requested. The block keeps a pointer that advances after each data byte. The pointer is confined to the section it started in, and it survives the end of a transfer so that a later read without an address picks up where the last one stopped.

The map has four sections. The time-keeping section holds eight bytes: seven at 00h..06h and a hundredths byte at 1Fh. The timekeeper owns these bytes. The block sees them on a live input and sends accepted writes back to the timekeeper as one-cycle pulses. The control/status section (07h..0Bh), alarm section (0Ch..11h) and timer section (12h..14h) are stored locally and exposed as a flat image for the neighbouring logic. Addresses 15h..1Eh hold nothing.

To keep multi-byte time reads coherent, time-keeping bytes are read from a shadow copy. The copy follows the live value every cycle until a read lands in the time-keeping or alarm section. It then freezes until the next start or stop strobe.

Top module: `sect_reg_ctrl`

## Requirements
- R1: While reset is low and on leaving it, `rd_byte` is 00h, `time_wr_en` is 0 and every byte of `reg_img` is 00h.
- R2: An `addr_vld` strobe loads the pointer from the low five bits of `addr_byte`; bits 7:5 are ignored, so 3Fh selects 1Fh. Each `wr_vld` or `rd_req` acts at the pointer and then advances it. The pointer keeps its value across stop and start, so a read with no new address continues at the next byte.
- R3: Advancing never leaves a section. The time-keeping order is 1Fh, 00h, 01h … 06h, and 06h is followed by 1Fh. 0Bh is followed by 07h, 11h by 0Ch, 14h by 12h, and 1Eh by 15h.
- R4: A write to a time-keeping address produces one `time_wr_en` pulse in the cycle after the strobe, carrying the data byte and a byte select (00h..06h give 0..6, 1Fh gives 7). This happens only while bit 4 of register 07h is 1; otherwise there is no pulse and the time is unchanged.
- R5: A write to 07h..14h stores the byte in `reg_img` at byte lane (address − 07h), and a later read of 07h..13h returns it.
- R6: A read of 14h returns 00h, even though the written byte is kept in `reg_img` lane 13.
- R7: A read of 15h..1Eh returns 00h. A write there changes neither `reg_img` nor the time.
- R8: A read in the time-keeping or alarm section freezes the shadow copy in that same cycle. Time-keeping reads then return the frozen bytes, even when the live time changes in the very cycle of the first read, until a start or stop strobe.
- R9: Once released, the shadow copy follows the live time with one cycle of lag, so a read two cycles after a stop returns the current time.
- R10: `rd_byte` is registered. It takes the new value in the cycle after `rd_req` and holds it until the next `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start or repeated start seen by the framer |
| xfer_stop | input | 1 | Stop seen by the framer |
| addr_vld | input | 1 | Register address byte valid |
| addr_byte | input | DW | Register address byte |
| wr_vld | input | 1 | Write data byte valid |
| wr_byte | input | DW | Write data byte |
| rd_req | input | 1 | Request for the next read byte |
| rd_byte | output | DW | Read data, registered |
| time_live | input | CLK_N*DW | Live time-keeping bytes, byte k in lane k (lane 7 = hundredths) |
| time_wr_en | output | 1 | Accepted time-keeping write pulse |
| time_wr_sel | output | $clog2(CLK_N) | Time-keeping byte lane being written |
| time_wr_byte | output | DW | Time-keeping write data |
| reg_img | output | LOC_N*DW | Local registers 07h..14h, lane 0 = 07h |

## Verification
The case that matters is the first byte of a time read landing in the same clock cycle as a change of the live time. If it is mishandled, the first byte shows the old time and the following bytes show the new one. The bench sends `rd_req` in the same cycle as an increment of every live byte. It expects the first byte and the next one both to carry the pre-increment values. After a stop, a fresh read must show the incremented values. A second run releases the shadow with a start strobe instead of a stop.

// File: rtl/sra_pkg.sv
package sra_pkg;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        SEC_TIME,
        SEC_CTRL,
        SEC_ALRM,
        SEC_TIMR,
        SEC_NONE
    } sec_e;

    localparam logic [ADDR_W-1:0] A_HUND     = 5'h1F;
    localparam logic [ADDR_W-1:0] A_TIME_END = 5'h06;
    localparam logic [ADDR_W-1:0] A_CTRL_LO  = 5'h07;
    localparam logic [ADDR_W-1:0] A_CTRL_HI  = 5'h0B;
    localparam logic [ADDR_W-1:0] A_ALRM_LO  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_ALRM_HI  = 5'h11;
    localparam logic [ADDR_W-1:0] A_TIMR_LO  = 5'h12;
    localparam logic [ADDR_W-1:0] A_TIMR_HI  = 5'h14;
    localparam logic [ADDR_W-1:0] A_NONE_LO  = 5'h15;
    localparam logic [ADDR_W-1:0] A_NONE_HI  = 5'h1E;
    localparam int                GATE_BIT   = 4;

    function automatic sec_e sec_of(input logic [ADDR_W-1:0] a);
        if (a <= A_TIME_END || a == A_HUND) return SEC_TIME;
        if (a <= A_CTRL_HI)                 return SEC_CTRL;
        if (a <= A_ALRM_HI)                 return SEC_ALRM;
        if (a <= A_TIMR_HI)                 return SEC_TIMR;
        return SEC_NONE;
    endfunction
endpackage

// File: rtl/sra_ptr_next.sv
module sra_ptr_next
    import sra_pkg::*;
(
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);
    always_comb begin
        unique case (cur)
            A_HUND:     nxt = '0;
            A_TIME_END: nxt = A_HUND;
            A_CTRL_HI:  nxt = A_CTRL_LO;
            A_ALRM_HI:  nxt = A_ALRM_LO;
            A_TIMR_HI:  nxt = A_TIMR_LO;
            A_NONE_HI:  nxt = A_NONE_LO;
            default:    nxt = cur + 1'b1;
        endcase
    end
endmodule

// File: rtl/sra_snap.sv
module sra_snap #(
    parameter int DW    = 8,
    parameter int CLK_N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CLK_N*DW-1:0]   live,
    input  logic                  hold_set,
    input  logic                  hold_clr,
    output logic [CLK_N*DW-1:0]   shadow,
    output logic                  held
);
    typedef struct packed {
        logic                hold;
        logic [CLK_N*DW-1:0] img;
    } snap_t;

    snap_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!(s_q.hold || hold_set)) s_d.img = live;
        if (hold_set)       s_d.hold = 1'b1;
        else if (hold_clr)  s_d.hold = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shadow = s_q.img;
    assign held   = s_q.hold;
endmodule

// File: rtl/sect_reg_ctrl.sv
module sect_reg_ctrl
    import sra_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CLK_N = 8,
    parameter int LOC_N = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xfer_start,
    input  logic                     xfer_stop,
    input  logic                     addr_vld,
    input  logic [DW-1:0]            addr_byte,
    input  logic                     wr_vld,
    input  logic [DW-1:0]            wr_byte,
    input  logic                     rd_req,
    output logic [DW-1:0]            rd_byte,
    input  logic [CLK_N*DW-1:0]      time_live,
    output logic                     time_wr_en,
    output logic [$clog2(CLK_N)-1:0] time_wr_sel,
    output logic [DW-1:0]            time_wr_byte,
    output logic [LOC_N*DW-1:0]      reg_img
);
    localparam int SEL_W = $clog2(CLK_N);
    localparam int LOC_W = $clog2(LOC_N);

    typedef struct packed {
        logic [ADDR_W-1:0]          ptr;
        logic [LOC_N-1:0][DW-1:0]   regs;
        logic [DW-1:0]              rdat;
        logic                       twr_en;
        logic [SEL_W-1:0]           twr_sel;
        logic [DW-1:0]              twr_byte;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0]          ptr_nxt;
    logic [CLK_N-1:0][DW-1:0]   shadow;
    logic                       held;
    logic                       hold_set;
    sec_e                       sec;
    logic [ADDR_W-1:0]          loc_off;
    logic [SEL_W-1:0]           tidx;
    logic                       gate;

    sra_ptr_next u_next (
        .cur (st_q.ptr),
        .nxt (ptr_nxt)
    );

    sra_snap #(.DW(DW), .CLK_N(CLK_N)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (time_live),
        .hold_set (hold_set),
        .hold_clr (xfer_start | xfer_stop),
        .shadow   (shadow),
        .held     (held)
    );

    always_comb begin
        sec      = sec_of(st_q.ptr);
        loc_off  = st_q.ptr - A_CTRL_LO;
        tidx     = (st_q.ptr == A_HUND) ? SEL_W'(CLK_N - 1) : st_q.ptr[SEL_W-1:0];
        gate     = st_q.regs[0][GATE_BIT];
        hold_set = rd_req && (sec == SEC_TIME || sec == SEC_ALRM);

        st_d        = st_q;
        st_d.twr_en = 1'b0;

        if (addr_vld)
            st_d.ptr = addr_byte[ADDR_W-1:0];
        else if (wr_vld || rd_req)
            st_d.ptr = ptr_nxt;

        if (wr_vld) begin
            unique case (sec)
                SEC_TIME: begin
                    if (gate) begin
                        st_d.twr_en   = 1'b1;
                        st_d.twr_sel  = tidx;
                        st_d.twr_byte = wr_byte;
                    end
                end
                SEC_CTRL, SEC_ALRM, SEC_TIMR:
                    st_d.regs[loc_off[LOC_W-1:0]] = wr_byte;
                default: ;
            endcase
        end

        if (rd_req) begin
            unique case (sec)
                SEC_TIME:           st_d.rdat = shadow[tidx];
                SEC_CTRL, SEC_ALRM: st_d.rdat = st_q.regs[loc_off[LOC_W-1:0]];
                SEC_TIMR:           st_d.rdat = (st_q.ptr == A_TIMR_HI) ? '0
                                                : st_q.regs[loc_off[LOC_W-1:0]];
                default:            st_d.rdat = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_byte      = st_q.rdat;
    assign time_wr_en   = st_q.twr_en;
    assign time_wr_sel  = st_q.twr_sel;
    assign time_wr_byte = st_q.twr_byte;
    assign reg_img      = st_q.regs;
endmodule

// File: rtl/sect_reg_ctrl_chk.sv
module sect_reg_ctrl_chk #(
    parameter int DW    = 8,
    parameter int CLK_N = 8,
    parameter int LOC_N = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 addr_vld,
    input logic                 wr_vld,
    input logic                 rd_req,
    input logic [4:0]           ptr,
    input logic [DW-1:0]        rd_byte,
    input logic                 time_wr_en,
    input logic [LOC_N*DW-1:0]  reg_img,
    input logic                 held,
    input logic [CLK_N*DW-1:0]  shadow
);
    a_r4_gated_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr_en |-> ($past(wr_vld) && $past(reg_img[4])));

    a_r3_time_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_vld || rd_req) && !addr_vld && ptr == 5'h06) |=> (ptr == 5'h1F));

    a_r3_timer_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_vld || rd_req) && !addr_vld && ptr == 5'h14) |=> (ptr == 5'h12));

    a_r6_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ptr == 5'h14) |=> (rd_byte == '0));

    a_r7_unused_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && ptr >= 5'h15 && ptr <= 5'h1E) |=> ($stable(reg_img) && !time_wr_en));

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(held) && held) |-> $stable(shadow));

    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_byte));
endmodule

bind sect_reg_ctrl sect_reg_ctrl_chk #(.DW(DW), .CLK_N(CLK_N), .LOC_N(LOC_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_vld   (addr_vld),
    .wr_vld     (wr_vld),
    .rd_req     (rd_req),
    .ptr        (st_q.ptr),
    .rd_byte    (rd_byte),
    .time_wr_en (time_wr_en),
    .reg_img    (reg_img),
    .held       (held),
    .shadow     (shadow)
);

// File: tb/sect_reg_ctrl_tb.sv
module sect_reg_ctrl_tb;
    localparam logic [2:0] OP_ADDR = 3'd0;
    localparam logic [2:0] OP_WR   = 3'd1;
    localparam logic [2:0] OP_RD   = 3'd2;
    localparam logic [2:0] OP_STOP = 3'd3;
    localparam int NV = 64;

    // {req[3:0], op[2:0], arg[7:0], expected[7:0]}
    localparam logic [22:0] VEC [NV] = '{
        {4'd5, OP_ADDR, 8'h07, 8'h00}, {4'd5, OP_WR, 8'h50, 8'h00},
        {4'd5, OP_WR, 8'h11, 8'h00},   {4'd5, OP_WR, 8'h22, 8'h00},
        {4'd5, OP_WR, 8'h33, 8'h00},   {4'd5, OP_WR, 8'h44, 8'h00},
        {4'd3, OP_WR, 8'h55, 8'h00},   {4'd3, OP_STOP, 8'h00, 8'h00},
        // R5 readback, R3 wrap 0Bh->07h
        {4'd5, OP_ADDR, 8'h07, 8'h00}, {4'd5, OP_RD, 8'h00, 8'h55},
        {4'd5, OP_RD, 8'h00, 8'h11},   {4'd5, OP_RD, 8'h00, 8'h22},
        {4'd5, OP_RD, 8'h00, 8'h33},   {4'd5, OP_RD, 8'h00, 8'h44},
        {4'd3, OP_RD, 8'h00, 8'h55},   {4'd3, OP_STOP, 8'h00, 8'h00},
        // timer section, R6 write-only byte
        {4'd5, OP_ADDR, 8'h12, 8'h00}, {4'd5, OP_WR, 8'hA1, 8'h00},
        {4'd5, OP_WR, 8'hB2, 8'h00},   {4'd6, OP_WR, 8'hC3, 8'h00},
        {4'd3, OP_WR, 8'hD4, 8'h00},   {4'd3, OP_STOP, 8'h00, 8'h00},
        {4'd5, OP_ADDR, 8'h13, 8'h00}, {4'd5, OP_RD, 8'h00, 8'hB2},
        {4'd6, OP_RD, 8'h00, 8'h00},   {4'd3, OP_RD, 8'h00, 8'hD4},
        {4'd3, OP_STOP, 8'h00, 8'h00},
        // R3 time order 06h -> 1Fh -> 00h
        {4'd3, OP_ADDR, 8'h06, 8'h00}, {4'd3, OP_RD, 8'h00, 8'h16},
        {4'd3, OP_RD, 8'h00, 8'h17},   {4'd3, OP_RD, 8'h00, 8'h10},
        {4'd3, OP_STOP, 8'h00, 8'h00},
        // R2 current-address read continues at 01h
        {4'd2, OP_RD, 8'h00, 8'h11},   {4'd2, OP_STOP, 8'h00, 8'h00},
        // R7 unused region, R3 wrap 1Eh -> 15h
        {4'd7, OP_ADDR, 8'h1E, 8'h00}, {4'd7, OP_WR, 8'h99, 8'h00},
        {4'd7, OP_WR, 8'h77, 8'h00},   {4'd7, OP_STOP, 8'h00, 8'h00},
        {4'd7, OP_ADDR, 8'h1E, 8'h00}, {4'd7, OP_RD, 8'h00, 8'h00},
        {4'd7, OP_RD, 8'h00, 8'h00},   {4'd7, OP_STOP, 8'h00, 8'h00},
        // R2 upper address bits ignored
        {4'd2, OP_ADDR, 8'h3F, 8'h00}, {4'd2, OP_RD, 8'h00, 8'h17},
        // R4 enabled time write
        {4'd4, OP_ADDR, 8'h02, 8'h00}, {4'd4, OP_WR, 8'h5A, 8'h00},
        {4'd4, OP_STOP, 8'h00, 8'h00}, {4'd4, OP_ADDR, 8'h02, 8'h00},
        {4'd4, OP_RD, 8'h00, 8'h5A},   {4'd4, OP_STOP, 8'h00, 8'h00},
        // R4 gate cleared, write blocked
        {4'd4, OP_ADDR, 8'h07, 8'h00}, {4'd4, OP_WR, 8'h40, 8'h00},
        {4'd4, OP_STOP, 8'h00, 8'h00}, {4'd4, OP_ADDR, 8'h03, 8'h00},
        {4'd4, OP_WR, 8'h66, 8'h00},   {4'd4, OP_STOP, 8'h00, 8'h00},
        {4'd4, OP_ADDR, 8'h03, 8'h00}, {4'd4, OP_RD, 8'h00, 8'h13},
        // R3 alarm wrap 11h -> 0Ch
        {4'd3, OP_ADDR, 8'h11, 8'h00}, {4'd3, OP_WR, 8'h0E, 8'h00},
        {4'd3, OP_WR, 8'h0F, 8'h00},   {4'd3, OP_ADDR, 8'h0C, 8'h00},
        {4'd3, OP_RD, 8'h00, 8'h0F},   {4'd3, OP_STOP, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_stop = 1'b0;
    logic        addr_vld = 1'b0, wr_vld = 1'b0, rd_req = 1'b0;
    logic [7:0]  addr_byte = '0, wr_byte = '0;
    logic [7:0]  rd_byte;
    logic [63:0] time_live;
    logic        time_wr_en;
    logic [2:0]  time_wr_sel;
    logic [7:0]  time_wr_byte;
    logic [111:0] reg_img;

    logic [7:0]  live [8];
    logic        bump = 1'b0;
    int          pulses = 0;
    int          n_chk = 0, n_bad = 0;
    logic [111:0] img_keep;

    always #4 clk = ~clk;

    sect_reg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .addr_vld(addr_vld), .addr_byte(addr_byte), .wr_vld(wr_vld), .wr_byte(wr_byte),
        .rd_req(rd_req), .rd_byte(rd_byte), .time_live(time_live),
        .time_wr_en(time_wr_en), .time_wr_sel(time_wr_sel), .time_wr_byte(time_wr_byte),
        .reg_img(reg_img)
    );

    // timekeeper model
    initial for (int i = 0; i < 8; i++) live[i] = 8'h10 + 8'(i);
    always @(posedge clk) begin
        if (time_wr_en) begin
            live[time_wr_sel] <= time_wr_byte;
            pulses <= pulses + 1;
        end else if (bump) begin
            for (int i = 0; i < 8; i++) live[i] <= live[i] + 8'h01;
        end
    end
    always_comb for (int i = 0; i < 8; i++) time_live[i*8 +: 8] = live[i];

    task automatic check(input string req, input logic [111:0] act, input logic [111:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // caller sits at a negedge; op occupies one cycle
    task automatic do_op(input logic [2:0] op, input logic [7:0] arg);
        addr_vld  = (op == OP_ADDR);
        wr_vld    = (op == OP_WR);
        rd_req    = (op == OP_RD);
        xfer_stop = (op == OP_STOP);
        addr_byte = arg;
        wr_byte   = arg;
        @(negedge clk);
        addr_vld = 0; wr_vld = 0; rd_req = 0; xfer_stop = 0;
    endtask

    initial begin
        #1_600_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", 112'(rd_byte), 112'h0);
        check("R1", 112'(time_wr_en), 112'h0);
        check("R1", reg_img, 112'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", reg_img, 112'h0);

        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            e = VEC[v];
            do_op(e[18:16], e[15:8]);
            if (e[18:16] == OP_RD)
                check($sformatf("R%0d vec %0d", e[22:19], v), 112'(rd_byte), 112'(e[7:0]));
        end

        // R5 image lanes
        check("R5", 112'(reg_img[3*8 +: 8]), 112'h33);
        check("R5", 112'(reg_img[0 +: 8]), 112'h40);
        check("R6", 112'(reg_img[13*8 +: 8]), 112'hC3);
        // R4 only one accepted time write so far
        check("R4", 112'(pulses), 112'd1);

        // R7 unused write leaves image and time alone
        img_keep = reg_img;
        do_op(OP_ADDR, 8'h18);
        do_op(OP_WR, 8'hFF);
        @(negedge clk);
        check("R7", reg_img, img_keep);
        check("R7", 112'(pulses), 112'd1);

        // R8 live change in the same cycle as the first read
        do_op(OP_STOP, 8'h00);
        do_op(OP_ADDR, 8'h00);
        bump = 1'b1;
        do_op(OP_RD, 8'h00);
        bump = 1'b0;
        check("R8", 112'(rd_byte), 112'h10);
        do_op(OP_RD, 8'h00);
        check("R8", 112'(rd_byte), 112'h11);
        // R10 held while idle
        repeat (3) @(negedge clk);
        check("R10", 112'(rd_byte), 112'h11);
        // R9 released by stop
        do_op(OP_STOP, 8'h00);
        @(negedge clk);
        do_op(OP_ADDR, 8'h00);
        do_op(OP_RD, 8'h00);
        check("R9", 112'(rd_byte), 112'h11);

        // R8 release by start strobe
        bump = 1'b1;
        @(negedge clk);
        bump = 1'b0;
        do_op(OP_RD, 8'h00);
        check("R8", 112'(rd_byte), 112'h12);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        @(negedge clk);
        do_op(OP_ADDR, 8'h01);
        do_op(OP_RD, 8'h00);
        check("R8", 112'(rd_byte), 112'h13);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule